// File: doc/BRIEF.md
# Byte-Serial Transceiver with Split Baud Divisor

This block is an asynchronous serial port for one start bit, eight data bits and one stop bit, reached through a small register bus. Software sets the line rate by writing a 16-bit divisor as two byte-wide halves. The block divides its clock by that divisor to make a tick that runs at sixteen times the bit rate. Both directions pace themselves on that tick.

A byte written to the transmit register waits in a one-byte holding stage. It then moves into a shift register and goes out least significant bit first. The receiver watches the line on every tick. It confirms a start bit half a bit after the falling edge and then takes each data bit near the centre of its cell. Software polls a read-only status register to learn whether a received byte is waiting, whether the holding stage can take another byte, and whether the last frame ended with a bad stop bit.

Top module: `uart_divlatch`

## Requirements
- R1: Address 1 holds the divisor's low byte and address 2 its high byte. Both read back what was written. After reset the divisor is DIV_INIT, which defaults to 1.
- R2: Every transmitted bit cell lasts exactly 16 × D clock cycles, where D = 256 × high + low. A divisor of 0 behaves as 1.
- R3: A transmitted frame is one low start bit, then the eight data bits least significant first, then one high stop bit. Between frames the line stays high.
- R4: Status bit 5 reads 1 when the holding stage is empty. A write to address 0 clears the bit in the cycle after the write. The bit returns to 1 once the byte has moved into the shift register, which takes at most one tick period.
- R5: A frame received on rxd stores its byte LSB first, and status bit 0 becomes 1 before the stop bit ends. Reading address 0 returns the byte.
- R6: A read of address 0 with rd_en high clears status bit 0 in the following cycle.
- R7: A low pulse on rxd shorter than half a bit cell does not start a frame, and status bit 0 stays 0.
- R8: A frame whose stop bit is sampled low still stores its byte and sets status bit 3. The next frame with a good stop bit clears bit 3.
- R9: The status register at address 3 is read-only. Writes to it change nothing.
- R10: After reset txd is high and the status register reads 0x60: bit 5 is set, and bit 6 is set because both the holding stage and the shift register are empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that the divisor divides |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 2 | Register select: 0 data, 1 divisor low, 2 divisor high, 3 status |
| wr_en | input | 1 | Write strobe, taken on the rising edge |
| rd_en | input | 1 | Consuming-read strobe; clears the data-ready bit when addr is 0 |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register (combinational) |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |

## Verification
A register write shows up on rdata at the negative edge after the write edge, so status bit 5 is checked there. Its return is then polled over at most one tick period plus one cycle. The transmit line is decoded from its falling edge: the bench waits 8 × D cycles to reach the centre of the start bit and then 16 × D cycles per cell. The start-bit width is measured in whole cycles against 16 × D. Received bytes and their status bits are read only after the full stop cell has been driven. By then the two-flop input synchroniser and the mid-stop sample have both completed. The clearing effect of a consuming read is checked at the very next negative edge.

// File: rtl/uart_divlatch.sv
module uart_divlatch #(
  parameter int          DATA_W   = 8,
  parameter int          DIV_W    = 16,
  parameter int          OVS      = 16,
  parameter logic [15:0] DIV_INIT = 16'd1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  addr,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  input  logic        rxd,
  output logic        txd
);
  localparam int CW   = $clog2(OVS);
  localparam int BW   = $clog2(DATA_W);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);
  localparam logic [CW-1:0] HALF = CW'(OVS / 2 - 1);

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} ser_t;

  // divisor latch and tick
  logic [7:0]       div_lo, div_hi;
  logic [DIV_W-1:0] div_eff, bcnt;
  logic             tick;
  wire  [15:0]      div_raw = {div_hi, div_lo};
  wire              div_wr  = wr_en && (addr == 2'd1 || addr == 2'd2);

  assign div_eff = (div_raw == 16'd0) ? DIV_W'(1) : DIV_W'(div_raw);
  assign tick    = (bcnt >= div_eff - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div_lo <= DIV_INIT[7:0];
      div_hi <= DIV_INIT[15:8];
      bcnt   <= '0;
    end else begin
      if (wr_en && addr == 2'd1) div_lo <= wdata;
      if (wr_en && addr == 2'd2) div_hi <= wdata;
      bcnt <= tick ? '0 : bcnt + DIV_W'(1);
    end

  // transmitter
  ser_t              tx_st;
  logic [DATA_W-1:0] thr, tsh;
  logic              thr_full;
  logic [CW-1:0]     tcnt;
  logic [BW-1:0]     tbit;
  wire               thr_wr  = wr_en && addr == 2'd0;
  wire               tx_load = tick && tx_st == S_IDLE && thr_full;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_st <= S_IDLE; thr <= '0; tsh <= '0; thr_full <= 1'b0;
      tcnt <= '0; tbit <= '0;
    end else begin
      if (thr_wr) thr <= wdata;
      thr_full <= thr_wr ? 1'b1 : (tx_load ? 1'b0 : thr_full);
      if (tick) begin
        case (tx_st)
          S_IDLE: if (thr_full) begin
            tsh <= thr; tx_st <= S_START; tcnt <= '0;
          end
          S_START: begin
            tcnt <= tcnt + CW'(1);
            if (tcnt == LAST) begin tx_st <= S_DATA; tbit <= '0; end
          end
          S_DATA: begin
            tcnt <= tcnt + CW'(1);
            if (tcnt == LAST) begin
              tsh  <= tsh >> 1;
              tbit <= tbit + BW'(1);
              if (tbit == BW'(DATA_W - 1)) tx_st <= S_STOP;
            end
          end
          S_STOP: begin
            tcnt <= tcnt + CW'(1);
            if (tcnt == LAST) tx_st <= S_IDLE;
          end
        endcase
      end
    end

  assign txd = (tx_st == S_START) ? 1'b0 : (tx_st == S_DATA) ? tsh[0] : 1'b1;

  // receiver
  ser_t              rx_st;
  logic              rx_m, rx_s, rx_prev;
  logic [DATA_W-1:0] rsh, rbr;
  logic [CW-1:0]     rcnt;
  logic [BW-1:0]     rbit;
  logic              dr, ferr;
  wire               rx_done = tick && rx_st == S_STOP && rcnt == LAST;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_m <= 1'b1; rx_s <= 1'b1; rx_prev <= 1'b1;
      rx_st <= S_IDLE; rsh <= '0; rbr <= '0; rcnt <= '0; rbit <= '0;
      dr <= 1'b0; ferr <= 1'b0;
    end else begin
      rx_m <= rxd;
      rx_s <= rx_m;
      if (tick) begin
        rx_prev <= rx_s;
        case (rx_st)
          S_IDLE: if (rx_prev && !rx_s) begin rx_st <= S_START; rcnt <= '0; end
          S_START: begin
            rcnt <= rcnt + CW'(1);
            if (rcnt == HALF) begin
              rcnt  <= '0;
              rbit  <= '0;
              rx_st <= rx_s ? S_IDLE : S_DATA;
            end
          end
          S_DATA: begin
            rcnt <= rcnt + CW'(1);
            if (rcnt == LAST) begin
              rsh  <= {rx_s, rsh[DATA_W-1:1]};
              rbit <= rbit + BW'(1);
              if (rbit == BW'(DATA_W - 1)) rx_st <= S_STOP;
            end
          end
          S_STOP: begin
            rcnt <= rcnt + CW'(1);
            if (rcnt == LAST) rx_st <= S_IDLE;
          end
        endcase
      end
      if (rx_done) begin
        rbr  <= rsh;
        dr   <= 1'b1;
        ferr <= !rx_s;
      end else if (rd_en && addr == 2'd0) begin
        dr <= 1'b0;
      end
    end

  // register read
  wire       tx_idle = !thr_full && tx_st == S_IDLE;
  wire [7:0] lsr     = {1'b0, tx_idle, !thr_full, 1'b0, ferr, 2'b00, dr};

  always_comb
    case (addr)
      2'd0:    rdata = 8'(rbr);
      2'd1:    rdata = div_lo;
      2'd2:    rdata = div_hi;
      default: rdata = lsr;
    endcase

  // assertions
  assert_zero_div_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (div_raw == 16'd0) |-> tick);
  assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_eff > DIV_W'(1) && !div_wr) |=> !tick);
  assert_thr_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> !lsr[5]);
  assert_dr_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dr) |-> $past(rx_done));
  assert_dr_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd0 && !rx_done) |=> !dr);
  assert_idle_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lsr[6] |-> txd);
endmodule

// File: tb/uart_divlatch_tb.sv
module uart_divlatch_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] addr = 2'd3;
  logic wr_en = 1'b0, rd_en = 1'b0, rxd = 1'b1;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic txd;
  int total = 0, bad = 0, cyc = 0;
  int dv = 1;

  always #2 clk = ~clk;

  uart_divlatch u_dut (.clk, .rst_n, .addr, .wr_en, .rd_en, .wdata, .rdata, .rxd, .txd);

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; addr = 2'd3;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata; addr = 2'd3;
  endtask

  task automatic set_div(input int d);
    wr(2'd1, d[7:0]); wr(2'd2, d[15:8]);
    dv = (d == 0) ? 1 : d;
  endtask

  // write byte, check R4, decode the frame on txd
  task automatic tx_byte(input logic [7:0] b, input string req);
    logic [7:0] got; logic okf; int w;
    @(negedge clk); addr = 2'd0; wdata = b; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; addr = 2'd3;
    #1 check("R4 thre clears", int'(rdata[5]), 0);
    w = 0;
    while (!rdata[5] && w < dv + 2) begin @(negedge clk); #1 w++; end
    check("R4 thre returns", int'(rdata[5]), 1);
    w = 0;
    while (txd && w < 64 * dv) begin @(negedge clk); w++; end
    repeat (8 * dv) @(negedge clk);
    okf = (txd == 1'b0);
    for (int i = 0; i < 8; i++) begin
      repeat (16 * dv) @(negedge clk);
      got[i] = txd;
    end
    repeat (16 * dv) @(negedge clk);
    okf = okf && txd;
    check({req, " frame byte"}, int'(got), int'(b));
    check({req, " start/stop"}, int'(okf), 1);
    repeat (8 * dv + 2) @(negedge clk);
  endtask

  task automatic rx_drive(input logic [7:0] b, input logic stopb);
    @(negedge clk); rxd = 1'b0;
    repeat (16 * dv) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (16 * dv) @(negedge clk);
    end
    rxd = stopb;
    repeat (16 * dv) @(negedge clk);
    rxd = 1'b1;
    repeat (16 * dv) @(negedge clk);
  endtask

  task automatic consume(output logic [7:0] d);
    @(negedge clk); addr = 2'd0; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0; addr = 2'd3;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 195000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected<195000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, d;
    int lo;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 / R1 reset state
    peek(2'd3, v); check("R10 lsr reset", int'(v), 'h60);
    check("R10 txd idle", int'(txd), 1);
    peek(2'd1, v); check("R1 div low reset", int'(v), 1);
    peek(2'd2, v); check("R1 div high reset", int'(v), 0);
    // R1 readback
    wr(2'd1, 8'h34); wr(2'd2, 8'h12);
    peek(2'd1, v); check("R1 div low", int'(v), 'h34);
    peek(2'd2, v); check("R1 div high", int'(v), 'h12);
    // R9 read-only status
    wr(2'd3, 8'h09); peek(2'd3, v); check("R9 lsr write ignored", int'(v), 'h60);
    wr(2'd3, 8'hFF); peek(2'd3, v); check("R9 lsr write ignored", int'(v), 'h60);
    // R2 bit cell width for several divisors, 0 acting as 1
    foreach (lo_list[k]) begin
      set_div(lo_list[k]);
      repeat (40) @(negedge clk);
      wr(2'd0, 8'hFF);
      while (txd) @(negedge clk);
      lo = 0;
      while (!txd) begin lo++; @(negedge clk); end
      check("R2 start cell width", lo, 16 * dv);
      repeat (16 * 10 * dv) @(negedge clk);
    end
    // R3/R4 sweep every byte at divisor 1
    set_div(1);
    for (int b = 0; b < 256; b++) tx_byte(b[7:0], "R3");
    // R3 at divisor 3
    set_div(3);
    tx_byte(8'hA5, "R3 div3"); tx_byte(8'h01, "R3 div3"); tx_byte(8'h80, "R3 div3");
    // R5/R6 sweep every byte at divisor 1
    set_div(1);
    for (int b = 0; b < 256; b++) begin
      rx_drive(b[7:0], 1'b1);
      peek(2'd3, v); check("R5 data ready", int'(v[0]), 1);
      consume(d); check("R5 rx byte", int'(d), b);
      #1 check("R6 ready cleared", int'(rdata[0]), 0);
    end
    // R5 at divisor 2
    set_div(2);
    rx_drive(8'h3C, 1'b1); consume(d); check("R5 rx div2", int'(d), 'h3C);
    // R7 short glitch
    @(negedge clk); rxd = 1'b0; repeat (4 * dv) @(negedge clk); rxd = 1'b1;
    repeat (16 * 11 * dv) @(negedge clk);
    peek(2'd3, v); check("R7 glitch rejected", int'(v[0]), 0);
    // R8 framing error then recovery
    rx_drive(8'h5A, 1'b0);
    peek(2'd3, v); check("R8 ferr set", int'(v[3]), 1);
    check("R8 ready with bad stop", int'(v[0]), 1);
    consume(d); check("R8 byte kept", int'(d), 'h5A);
    rx_drive(8'hC3, 1'b1);
    peek(2'd3, v); check("R8 ferr cleared", int'(v[3]), 0);
    consume(d); check("R8 next byte", int'(d), 'hC3);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  int lo_list[3] = '{3, 0, 5};
endmodule